// File: doc/BRIEF.md
# Over-Current Pulse-Skip and Latch Sequencer

This block sits in each channel of a dual-channel switching regulator controller and decides what happens after the current-limit comparator trips. It watches two inputs. One is the channel's cycle-start strobe, a single-clock pulse at the start of each switching period. The other is the current-limit detect flag. The flag only matters on a clock where the strobe is high. A trip seen while the sequencer is idle starts a burst of skipped cycles, during which the high-side switch may not turn on.

After the skip burst, the high-side drive is released and the sequencer observes a window of cycle starts. A second trip inside that window sets a sticky over-current latch, and the chip-level supervisor uses it to shut the converter down. A window with no trip returns the sequencer to idle. Only dropping the enable input or an asynchronous reset clears the latch. The cycle counts are parameters: the defaults give 8 skipped cycles after the trip cycle and an 8-cycle window.

Top module: `oc_skip_latch`

## Requirements
- R1: While rst_n is low, and at the first sample after it is released, hs_inhibit and oc_latch are both 0.
- R2: A cycle_start pulse with ilim_trip high while the sequencer is idle sets hs_inhibit to 1 on the following clock. This is the trip cycle, counted as cycle 0.
- R3: hs_inhibit stays 1 through cycle starts 1 to 8 after the trip. ilim_trip is ignored at those cycle starts.
- R4: At cycle start 9 with ilim_trip low, hs_inhibit returns to 0. It stays 0 through cycle start 16 while no trip is seen.
- R5: ilim_trip high at any cycle start from 9 to 16 sets oc_latch to 1 and hs_inhibit to 1 on the following clock.
- R6: If no trip is seen at cycle starts 9 to 16, the sequencer is idle after cycle start 16. A trip at cycle start 17 begins a new skip burst.
- R7: Once oc_latch is 1, it and hs_inhibit stay 1 while enable stays high, whatever cycle_start and ilim_trip do.
- R8: enable low clears oc_latch and hs_inhibit on the next clock and returns the sequencer to idle. It takes priority over a strobe in the same clock, and cycle starts are ignored while enable is low.
- R9: With enable high, hs_inhibit changes only on a clock where cycle_start is high. ilim_trip between cycle starts has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Channel enable; low clears the latch and the sequencer |
| cycle_start | input | 1 | Single-clock strobe at the start of each switching cycle |
| ilim_trip | input | 1 | Current-limit detect flag, sampled only with cycle_start |
| hs_inhibit | output | 1 | High blocks high-side turn-on for the current cycle |
| oc_latch | output | 1 | Sticky over-current shutdown flag to the supervisor |

## Verification
Two decisions can land on the same clock edge. The first is a trip strobe arriving together with enable dropping. The bench drives both in one clock and expects the clear to win, so neither output rises. The second is the last window strobe, which can both end the window and carry a trip. The bench presents a trip exactly at cycle start 16 and expects a latch rather than a return to idle. It then checks the opposite case, a clean cycle start 16 followed by a trip at 17, which must start a fresh skip burst.

// File: rtl/oc_seq_pkg.sv
package oc_seq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SKIP  = 2'd1,
    SQ_WATCH = 2'd2,
    SQ_LATCH = 2'd3
  } sq_state_e;
endpackage

// File: rtl/oc_cyc_counter.sv
module oc_cyc_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count_q, count_d;
  logic             count_en;

  always_comb begin
    count_en = clr | inc;
    count_d  = count_q;
    if (clr)                       count_d = '0;
    else if (count_q != CNT_MAX)   count_d = count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  assign count = count_q;

  // saturation of the cycle counter backing R3/R4 windows
  p_cnt_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == CNT_MAX && inc && !clr) |=> (count_q == CNT_MAX));
  p_cnt_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count_q == '0));
endmodule

// File: rtl/oc_seq_fsm.sv
module oc_seq_fsm
  import oc_seq_pkg::*;
#(
  parameter int SKIP_CYC = 8,
  parameter int WIN_CYC  = 8,
  parameter int CNT_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             strobe_i,
  input  logic             trip_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             cnt_clr_o,
  output logic             cnt_inc_o,
  output logic             inhibit_o,
  output logic             latch_o
);
  localparam logic [CNT_W-1:0] SKIP_END = CNT_W'(SKIP_CYC);
  localparam logic [CNT_W-1:0] WIN_END  = CNT_W'(SKIP_CYC + WIN_CYC - 1);

  sq_state_e st_q, st_d;
  logic      inh_q, inh_d;

  always_comb begin
    st_d      = st_q;
    inh_d     = inh_q;
    cnt_clr_o = 1'b0;
    cnt_inc_o = 1'b0;
    if (!en_i) begin
      st_d      = SQ_IDLE;
      inh_d     = 1'b0;
      cnt_clr_o = 1'b1;
    end else if (strobe_i) begin
      unique case (st_q)
        SQ_IDLE: begin
          if (trip_i) begin
            st_d      = SQ_SKIP;
            inh_d     = 1'b1;
            cnt_clr_o = 1'b1;
          end
        end
        SQ_SKIP: begin
          cnt_inc_o = 1'b1;
          if (count_i == SKIP_END) begin
            st_d  = trip_i ? SQ_LATCH : SQ_WATCH;
            inh_d = trip_i;
          end
        end
        SQ_WATCH: begin
          cnt_inc_o = 1'b1;
          if (trip_i) begin
            st_d  = SQ_LATCH;
            inh_d = 1'b1;
          end else if (count_i == WIN_END) begin
            st_d      = SQ_IDLE;
            cnt_clr_o = 1'b1;
          end
        end
        default: begin
          st_d  = SQ_LATCH;
          inh_d = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      inh_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      inh_q <= inh_d;
    end
  end

  assign inhibit_o = inh_q;
  assign latch_o   = (st_q == SQ_LATCH);

  p_latch_inhibits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    latch_o |-> inhibit_o);
  p_latch_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_o) |-> $past(strobe_i && trip_i && en_i));
  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_o && en_i) |=> latch_o);
  p_en_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!latch_o && !inhibit_o));
  p_strobe_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !strobe_i) |=> $stable(inhibit_o));
endmodule

// File: rtl/oc_skip_latch.sv
module oc_skip_latch #(
  parameter int SKIP_CYC = 8,
  parameter int WIN_CYC  = 8,
  parameter int CNT_W    = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic cycle_start,
  input  logic ilim_trip,
  output logic hs_inhibit,
  output logic oc_latch
);
  logic [CNT_W-1:0] count;
  logic             cnt_clr, cnt_inc;

  oc_cyc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .count (count)
  );

  oc_seq_fsm #(
    .SKIP_CYC (SKIP_CYC),
    .WIN_CYC  (WIN_CYC),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (enable),
    .strobe_i  (cycle_start),
    .trip_i    (ilim_trip),
    .count_i   (count),
    .cnt_clr_o (cnt_clr),
    .cnt_inc_o (cnt_inc),
    .inhibit_o (hs_inhibit),
    .latch_o   (oc_latch)
  );
endmodule

// File: tb/test_oc_skip_latch.sv
`timescale 1ns/1ps
module test_oc_skip_latch;
  logic clk = 1'b0;
  logic rst_n, enable, cycle_start, ilim_trip;
  logic hs_inhibit, oc_latch;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  oc_skip_latch i_oc_skip_latch (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cycle_start(cycle_start),
    .ilim_trip(ilim_trip), .hs_inhibit(hs_inhibit), .oc_latch(oc_latch)
  );

  task automatic check(input string req, input logic exp_inh, input logic exp_lat);
    n_chk++;
    if (hs_inhibit !== exp_inh || oc_latch !== exp_lat) begin
      n_bad++;
      $display("FAIL %s: inhibit=%b latch=%b expected inhibit=%b latch=%b",
               req, hs_inhibit, oc_latch, exp_inh, exp_lat);
    end
  endtask

  // one strobe; outputs sampled at the negedge after the capturing posedge
  task automatic strobe(input logic trip);
    @(negedge clk);
    cycle_start = 1'b1; ilim_trip = trip;
    @(negedge clk);
    cycle_start = 1'b0; ilim_trip = 1'b0;
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_enable();
    @(negedge clk); enable = 1'b0;
    @(negedge clk);
    check("R8 clear", 1'b0, 1'b0);
    strobe(1'b1);
    check("R8 ignored while low", 1'b0, 1'b0);
    enable = 1'b1;
    gap(1);
  endtask

  task automatic skip_burst();
    strobe(1'b1); check("R2 trip", 1'b1, 1'b0);
    for (int k = 1; k <= 8; k++) begin
      gap(2);
      strobe(1'b1); check("R3 skip", 1'b1, 1'b0);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; enable = 1'b1; cycle_start = 1'b0; ilim_trip = 1'b0;
    gap(3);
    check("R1 in reset", 1'b0, 1'b0);
    rst_n = 1'b1; gap(1);
    check("R1 after release", 1'b0, 1'b0);
  endtask

  task automatic t_quiet();
    strobe(1'b0); check("R2 no trip", 1'b0, 1'b0);
    @(negedge clk); ilim_trip = 1'b1; gap(3); ilim_trip = 1'b0;
    check("R9 trip without strobe", 1'b0, 1'b0);
  endtask

  task automatic t_recover();
    skip_burst();
    for (int k = 9; k <= 16; k++) begin
      gap(1);
      strobe(1'b0); check("R4 window", 1'b0, 1'b0);
    end
    strobe(1'b1); check("R6 retrigger at 17", 1'b1, 1'b0);
    gap(1); strobe(1'b1); check("R3 skip after retrigger", 1'b1, 1'b0);
    clear_enable();
  endtask

  task automatic t_latch_first();
    skip_burst();
    strobe(1'b1); check("R5 latch at 9", 1'b1, 1'b1);
    for (int k = 0; k < 3; k++) begin
      strobe(k[0]); check("R7 hold", 1'b1, 1'b1);
    end
    clear_enable();
  endtask

  task automatic t_latch_last();
    skip_burst();
    for (int k = 9; k <= 15; k++) strobe(1'b0);
    check("R4 before 16", 1'b0, 1'b0);
    strobe(1'b1); check("R5 latch at 16", 1'b1, 1'b1);
    clear_enable();
  endtask

  task automatic t_between();
    strobe(1'b1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); ilim_trip = ~ilim_trip;
      check("R9 stable between strobes", 1'b1, 1'b0);
    end
    ilim_trip = 1'b0;
    clear_enable();
  endtask

  task automatic t_collide();
    @(negedge clk);
    enable = 1'b0; cycle_start = 1'b1; ilim_trip = 1'b1;
    @(negedge clk);
    cycle_start = 1'b0; ilim_trip = 1'b0; enable = 1'b1;
    check("R8 enable beats strobe", 1'b0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_quiet();
    t_recover();
    t_latch_first();
    t_latch_last();
    t_between();
    t_collide();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule